// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block decides when each internal reset of a chip may be let go after power-up. Its input is an active-low reset pin. While the pin is low, every internal reset is held, and it is asserted at once without waiting for a clock edge. When the pin rises, a two-flop synchronizer on the reference clock releases the reset of the reference-clock logic first.

The sequencer then requires the pin to stay high for a programmable number of reference cycles. Any low during that time throws the whole block back into reset, so the count starts again from zero. After the window ends, the block pulses the PLL reset for a fixed minimum width so that the generated clocks realign with one another. It then waits for the PLL's synchronized completion flag before it releases the group of resets for the PLL-generated domains.

The test-clock domain has its own synchronizer on its own clock. That reset depends only on the pin and never on the PLL. A low on the pin after release returns every output to the fully reset state immediately. A state output lets a testbench follow the progress of the sequence.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `extRstN` is low, `refRstN`, `genRstN` and `tckRstN` are all 0, `pllRstOut` is 0 and `seqState` is 0. All of these take effect asynchronously.
- R2: `refRstN` goes to 1 at the second rising `refClk` edge after `extRstN` rises. At that point `genRstN` is still 0.
- R3: The stabilizing state (`seqState` = 1) lasts exactly max(1, `stableCount`) reference cycles and is then followed by the PLL-reset state.
- R4: A low on `extRstN` during the stabilizing state sends the block back to state 0. Once the pin is high again, a fresh full-length window is required.
- R5: `pllRstOut` is 1 only in state 2. State 2 lasts exactly `PULSE_W` cycles and is followed by state 3.
- R6: State 3 ends four cycles after `pllDone` has risen: one cycle for the PLL model's sampling edge, two synchronizer stages and the state update. The block then enters state 4. `genRstN` is all ones in state 4 and all zeros in every other state.
- R7: `tckRstN` is released by its own two-flop synchronizer on `tckClk` once the pin is high. It does not wait for the PLL.
- R8: A low on `extRstN` in state 4 returns all outputs to their R1 values at once.
- R9: The state encoding is 0 hold, 1 stabilizing, 2 PLL reset, 3 lock wait, 4 running. Apart from a return to 0, the state only ever steps up by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| tckClk | input | 1 | Test clock |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| pllDone | input | 1 | PLL lock / reset-complete flag, asynchronous |
| stableCount | input | CNT_W | Stability window length in reference cycles |
| pllRstOut | output | 1 | PLL reset, active high |
| refRstN | output | 1 | Reference-domain reset, active low |
| genRstN | output | NUM_GEN | Generated-domain resets, active low |
| tckRstN | output | 1 | Test-clock domain reset, active low |
| seqState | output | 3 | Sequencer state code |

## Verification
The checker watches several properties on every reference cycle:
- the state steps forward by one at a time;
- the measured length of the stabilizing window and of the PLL pulse;
- the generated resets release only after the lock flag was seen high;
- the reference reset is never behind the generated ones;
- everything is held while the pin is low.

Some behaviour only the bench scenarios can show. These include the exact two-edge release of the reference reset, the lock-wait latency against a delayed PLL model, a window restarted by a sub-cycle glitch, the boundary window of one cycle, a stuck PLL that holds the generated domains while the test-clock domain runs, and the immediate collapse on a pin drop after release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD     = 3'd0,
    ST_SETTLE   = 3'd1,
    ST_PLLPULSE = 3'd2,
    ST_LOCKWAIT = 3'd3,
    ST_RUN      = 3'd4
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntEnable;
  } dp_ctrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic winDone;
    logic pulseDone;
  } dp_flags_t;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchronizer: asynchronous clear, synchronous set of a constant one.
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic dataIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], dataIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/rstseq_dp.sv
// Shared cycle counter for the stability window and the PLL reset pulse.
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 16
) (
  input  logic             clk,
  input  logic             arstN,
  input  dp_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] stableCount,
  output dp_flags_t        flags
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] PULSE_LIM = CW'(PULSE_W);

  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    nextCnt;
  logic [CW-1:0]    winLen;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)              cnt <= '0;
    else if (ctrl.cntClear)  cnt <= '0;
    else if (ctrl.cntEnable) cnt <= cnt + 1'b1;
  end

  always_comb begin
    nextCnt = {1'b0, cnt} + 1'b1;
    winLen  = (stableCount == '0) ? CW'(1) : {1'b0, stableCount};
    flags.winDone   = (nextCnt >= winLen);
    flags.pulseDone = (nextCnt >= PULSE_LIM);
  end
endmodule

// File: rtl/rstseq_ctrl.sv
// Sequencer state machine; reset asynchronously by the pin.
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       refReady,
  input  logic       lockSync,
  input  dp_flags_t  flags,
  output dp_ctrl_t   ctrl,
  output seq_state_e stateQ
);
  seq_state_e stateD;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) stateQ <= ST_HOLD;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_HOLD:     if (refReady)        stateD = ST_SETTLE;
      ST_SETTLE:   if (flags.winDone)   stateD = ST_PLLPULSE;
      ST_PLLPULSE: if (flags.pulseDone) stateD = ST_LOCKWAIT;
      ST_LOCKWAIT: if (lockSync)        stateD = ST_RUN;
      ST_RUN:                           stateD = ST_RUN;
      default:                          stateD = ST_HOLD;
    endcase
    ctrl.cntClear  = (stateD != stateQ) || (stateQ == ST_HOLD);
    ctrl.cntEnable = (stateQ == ST_SETTLE) || (stateQ == ST_PLLPULSE);
  end
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import rstseq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 16,
  parameter int NUM_GEN = 4,
  parameter int SYNC_N  = 2
) (
  input  logic               refClk,
  input  logic               tckClk,
  input  logic               extRstN,
  input  logic               pllDone,
  input  logic [CNT_W-1:0]   stableCount,
  output logic               pllRstOut,
  output logic               refRstN,
  output logic [NUM_GEN-1:0] genRstN,
  output logic               tckRstN,
  output logic [2:0]         seqState
);
  dp_ctrl_t   dpCtrl;
  dp_flags_t  dpFlags;
  seq_state_e stateQ;
  logic       lockSync;

  rstseq_sync #(.STAGES(SYNC_N)) uRefSync (
    .clk(refClk), .arstN(extRstN), .dataIn(1'b1), .syncOut(refRstN));

  rstseq_sync #(.STAGES(SYNC_N)) uTckSync (
    .clk(tckClk), .arstN(extRstN), .dataIn(1'b1), .syncOut(tckRstN));

  rstseq_sync #(.STAGES(SYNC_N)) uLockSync (
    .clk(refClk), .arstN(extRstN), .dataIn(pllDone), .syncOut(lockSync));

  rstseq_ctrl uCtrl (
    .clk(refClk), .arstN(extRstN), .refReady(refRstN), .lockSync(lockSync),
    .flags(dpFlags), .ctrl(dpCtrl), .stateQ(stateQ));

  rstseq_dp #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) uDp (
    .clk(refClk), .arstN(extRstN), .ctrl(dpCtrl), .stableCount(stableCount),
    .flags(dpFlags));

  assign pllRstOut = (stateQ == ST_PLLPULSE);
  assign seqState  = stateQ;

  for (genvar g = 0; g < NUM_GEN; g++) begin : gDom
    assign genRstN[g] = (stateQ == ST_RUN);
  end
endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk #(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 16,
  parameter int NUM_GEN = 4
) (
  input logic               refClk,
  input logic               extRstN,
  input logic               pllDone,
  input logic [CNT_W-1:0]   stableCount,
  input logic               pllRstOut,
  input logic               refRstN,
  input logic [NUM_GEN-1:0] genRstN,
  input logic               tckRstN,
  input logic [2:0]         seqState
);
  int hiCnt;
  int stabCnt;
  int winLen;

  assign winLen = (stableCount == '0) ? 1 : int'(stableCount);

  always_ff @(posedge refClk or negedge extRstN) begin
    if (!extRstN) begin
      hiCnt   <= 0;
      stabCnt <= 0;
    end else begin
      hiCnt   <= pllRstOut ? hiCnt + 1 : 0;
      stabCnt <= (seqState == 3'd1) ? stabCnt + 1 : 0;
    end
  end

  // R1: everything held while the pin is low
  always @(negedge refClk)
    if (!extRstN)
      a_r1_all_held: assert (!refRstN && genRstN == '0 && !tckRstN && !pllRstOut && seqState == 3'd0);

  a_r9_state_steps: assert property (@(posedge refClk) disable iff (!extRstN)
    (seqState != $past(seqState) && seqState != 3'd0) |-> seqState == $past(seqState) + 3'd1);

  a_r3_window_len: assert property (@(posedge refClk) disable iff (!extRstN)
    (seqState == 3'd2 && $past(seqState) == 3'd1) |-> stabCnt == winLen);

  a_r5_pulse_width: assert property (@(posedge refClk) disable iff (!extRstN)
    ($fell(pllRstOut) && seqState == 3'd3) |-> hiCnt == PULSE_W);

  a_r6_gen_after_lock: assert property (@(posedge refClk) disable iff (!extRstN)
    $rose(genRstN[0]) |-> $past(pllDone, 2));

  a_r2_ref_before_gen: assert property (@(posedge refClk) disable iff (!extRstN)
    genRstN[0] |-> refRstN);
endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .NUM_GEN(NUM_GEN)) uChk (
  .refClk(refClk), .extRstN(extRstN), .pllDone(pllDone), .stableCount(stableCount),
  .pllRstOut(pllRstOut), .refRstN(refRstN), .genRstN(genRstN), .tckRstN(tckRstN),
  .seqState(seqState));

// File: tb/sim_pwrup_rst_seq.sv
`timescale 1ns/100ps
module sim_pwrup_rst_seq;
  localparam int CNT_W = 16, PULSE_W = 16, NUM_GEN = 4, LOCK_DLY = 10;

  logic refClk = 1'b0, tckClk = 1'b0;
  logic extRstN = 1'b0;
  logic pllDone = 1'b1;
  logic pllStuck = 1'b0;
  int   lockCnt = LOCK_DLY;
  logic [CNT_W-1:0] stableCount = 16'd7;
  logic pllRstOut, refRstN, tckRstN;
  logic [NUM_GEN-1:0] genRstN;
  logic [2:0] seqState;

  always #2 refClk = ~refClk;
  always #5 tckClk = ~tckClk;

  pwrup_rst_seq #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .NUM_GEN(NUM_GEN)) u0 (
    .refClk(refClk), .tckClk(tckClk), .extRstN(extRstN), .pllDone(pllDone),
    .stableCount(stableCount), .pllRstOut(pllRstOut), .refRstN(refRstN),
    .genRstN(genRstN), .tckRstN(tckRstN), .seqState(seqState));

  // PLL model: lock drops during reset, returns LOCK_DLY cycles after
  always @(posedge refClk) begin
    if (pllRstOut) begin
      lockCnt <= 0;
      pllDone <= 1'b0;
    end else if (pllStuck) pllDone <= 1'b0;
    else if (lockCnt < LOCK_DLY) lockCnt <= lockCnt + 1;
    else pllDone <= 1'b1;
  end

  int checks = 0, errs = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct { logic [2:0] st; int dwell; } exp_t;
  exp_t expQ[$];
  exp_t e;
  logic [2:0] prevSt = 3'd0;
  int dwell = 0;

  task automatic pushExp(input logic [2:0] st, input int dw);
    exp_t x;
    x.st = st; x.dwell = dw;
    expQ.push_back(x);
  endtask

  function automatic string dwellReq(input logic [2:0] s);
    case (s)
      3'd1: return "R3 window";
      3'd2: return "R5 pulse";
      3'd3: return "R6 lockwait";
      default: return "R9 dwell";
    endcase
  endfunction

  // monitor: compare each state change against the expected queue
  always @(negedge refClk) begin
    if (seqState != prevSt) begin
      if (expQ.size() == 0) begin
        checks++; errs++;
        $display("FAIL R9 unexpected state actual %0d expected none", seqState);
      end else begin
        e = expQ.pop_front();
        check("R9 state", int'(seqState), int'(e.st));
        if (e.dwell >= 0) check(dwellReq(prevSt), dwell, e.dwell);
        check("R5 pllRst", int'(pllRstOut), int'(seqState == 3'd2));
        check("R6 genRst", int'(genRstN), (seqState == 3'd4) ? (1 << NUM_GEN) - 1 : 0);
        check("R2 refRst", int'(refRstN), int'(seqState != 3'd0));
      end
      prevSt = seqState;
      dwell  = 1;
    end else dwell++;
  end

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000 && expQ.size() != 0; i++) @(negedge refClk);
    check(req, expQ.size(), 0);
    repeat (3) @(negedge refClk);
  endtask

  task automatic dropPin;
    @(negedge refClk);
    pushExp(3'd0, -1);
    #1 extRstN = 1'b0;
    #0.5;
    check("R8 refRst", int'(refRstN), 0);
    check("R8 genRst", int'(genRstN), 0);
    check("R8 state", int'(seqState), 0);
    repeat (6) @(negedge refClk);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errs++;
    $display("FAIL watchdog actual running expected finished");
    report();
  end

  initial begin
    // R1: held in reset
    repeat (5) @(negedge refClk);
    check("R1 refRst", int'(refRstN), 0);
    check("R1 genRst", int'(genRstN), 0);
    check("R1 tckRst", int'(tckRstN), 0);
    check("R1 pllRst", int'(pllRstOut), 0);
    check("R1 state", int'(seqState), 0);

    // normal sequence, window 7
    stableCount = 16'd7;
    pushExp(3'd1, -1); pushExp(3'd2, 7); pushExp(3'd3, PULSE_W); pushExp(3'd4, LOCK_DLY + 4);
    extRstN = 1'b1;
    @(negedge refClk);
    check("R2 one edge", int'(refRstN), 0);
    @(negedge refClk);
    check("R2 two edges", int'(refRstN), 1);
    check("R2 gen held", int'(genRstN), 0);
    drain("R6 reach run");
    check("R6 run gen", int'(genRstN), (1 << NUM_GEN) - 1);
    check("R7 tck", int'(tckRstN), 1);
    dropPin();
    check("R1 tck after drop", int'(tckRstN), 0);

    // R4: glitch restarts window of 12
    stableCount = 16'd12;
    pushExp(3'd1, -1);
    extRstN = 1'b1;
    for (int i = 0; i < 100 && seqState != 3'd1; i++) @(negedge refClk);
    repeat (5) @(negedge refClk);
    pushExp(3'd0, -1); pushExp(3'd1, -1); pushExp(3'd2, 12);
    pushExp(3'd3, PULSE_W); pushExp(3'd4, LOCK_DLY + 4);
    #1 extRstN = 1'b0;
    #1 extRstN = 1'b1;
    drain("R4 restart");
    dropPin();

    // R3 boundary: window of one cycle
    stableCount = 16'd1;
    pushExp(3'd1, -1); pushExp(3'd2, 1); pushExp(3'd3, PULSE_W); pushExp(3'd4, LOCK_DLY + 4);
    extRstN = 1'b1;
    drain("R3 window one");
    dropPin();

    // stuck PLL: generated domains wait, test domain released
    stableCount = 16'd3;
    pllStuck = 1'b1;
    pushExp(3'd1, -1); pushExp(3'd2, 3); pushExp(3'd3, PULSE_W);
    extRstN = 1'b1;
    repeat (100) @(negedge refClk);
    check("R6 lock wait", int'(seqState), 3);
    check("R6 gen held", int'(genRstN), 0);
    check("R7 tck free", int'(tckRstN), 1);
    check("R2 ref free", int'(refRstN), 1);
    pushExp(3'd4, -1);
    pllStuck = 1'b0;
    drain("R6 late lock");
    dropPin();

    report();
  end
endmodule